// File: doc/BRIEF.md
# Synchronized SPI Word Slave

This block is the target side of a serial peripheral link. A remote master supplies the serial clock, the data line into the block and an active-low select. The block runs entirely on its own fast system clock. The three serial pins pass through a two-flop synchronizer, and the block detects the serial clock edges in the system clock domain. An internal shift register exchanges one word per frame with the master. The block sends out its transmit word most significant bit first while it collects the master's bits into a receive register.

Two static inputs set the clock polarity (`cfg_cpol`) and the clock phase (`cfg_cpha`). Together they select one of the four standard sampling modes. The local logic presents the next word to send on `tx_word`. The block takes that word when select goes active, and again at each point where a received word completes. A completed word appears on `rx_word` together with a one-cycle `rx_valid` strobe. While select stays low the block keeps exchanging words back to back. When select is released, the block stops driving its output and discards any unfinished word. The system clock must run at least four times faster than the serial clock.

Top module: `spi_word_slave`

## Requirements
- R1: After reset, `miso_oe` is 0 and `rx_valid` is 0.
- R2: While `sel_n` is high, `miso_oe` is 0 (MISO at high impedance), and toggling `sclk` or `mosi` produces no `rx_valid` and leaves no effect on the next frame.
- R3: The leading serial clock edge is rising when `cfg_cpol`=0 and falling when `cfg_cpol`=1. MOSI is sampled on the leading edge when `cfg_cpha`=0 and on the trailing edge when `cfg_cpha`=1. MISO changes only on the other edge.
- R4: With `cfg_cpha`=0, bit WORD_W-1 of the transmit word is on `miso` with `miso_oe`=1 once select has gone low, before any serial clock edge.
- R5: After WORD_W sampling edges, `rx_word` holds the master's bits, with the first bit received at bit WORD_W-1. The master has then received the transmit word, most significant bit first.
- R6: Each completed word raises `rx_valid` for exactly one system clock cycle.
- R7: While select stays low, further words are exchanged back to back. The transmit word for each following word is the value of `tx_word` in the cycle that `rx_valid` rises.
- R8: A word cut short by select rising is discarded and produces no `rx_valid`.
- R9: While the block is selected, `miso` holds its value except in the cycle after a shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| mosi | input | 1 | Serial data from the master |
| sel_n | input | 1 | Active-low select from the master |
| miso | output | 1 | Serial data to the master, high impedance when disabled |
| miso_oe | output | 1 | Output enable for `miso` |
| tx_word | input | WORD_W | Word to send in the next frame |
| rx_word | output | WORD_W | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe for a completed word |

## Verification
The assertions assume two things about the inputs. First, each level on the serial clock lasts several system cycles, so that a sampling edge and a shift edge never land in the same cycle or in adjacent cycles. Second, the configuration inputs change only while select is high. The bench model of the master holds each serial clock level for four system cycles, which keeps a ratio of eight to one. It changes MOSI at least two cycles away from the sampling edge. It also switches modes only between frames, after select has been released for several cycles.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // Leading edge: the clock leaves its idle level.
  function automatic logic lead_edge(input logic cur, input logic prev, input logic cpol);
    return ((cur ^ cpol) & ~(prev ^ cpol));
  endfunction

  // Trailing edge: the clock returns to its idle level.
  function automatic logic trail_edge(input logic cur, input logic prev, input logic cpol);
    return (~(cur ^ cpol) & (prev ^ cpol));
  endfunction

  // True when the count of captured bits closes a word.
  function automatic logic word_done(input int unsigned cnt, input int unsigned width);
    return (cnt == width - 1);
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else if (g == 0) stage_q[g] <= d_in;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge
  import spi_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_ev,
  output logic shift_ev
);
  logic sclk_prev;
  logic lead_w, trail_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign lead_w    = lead_edge(sclk_s, sclk_prev, cpol);
  assign trail_w   = trail_edge(sclk_s, sclk_prev, cpol);
  assign sample_ev = cpha ? trail_w : lead_w;
  assign shift_ev  = cpha ? lead_w  : trail_w;

  // R3
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_ev, shift_ev}));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slv_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              mosi_s,
  input  logic              sample_ev,
  input  logic              shift_ev,
  input  logic              cpha,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              miso_d,
  output logic              miso_oe
);
  localparam int unsigned CW = $clog2(WORD_W);

  logic              active_q;
  logic              reload_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] tx_sr, nxt_q, rx_sr;
  logic              start_w, done_w;

  assign start_w = sel_act & ~active_q;
  assign done_w  = word_done(32'(cnt_q), WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      reload_q <= 1'b0;
      cnt_q    <= '0;
      tx_sr    <= '0;
      nxt_q    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel_act) begin
        active_q <= 1'b0;
        reload_q <= 1'b0;
        cnt_q    <= '0;
      end else if (start_w) begin
        active_q <= 1'b1;
        tx_sr    <= tx_word;
        nxt_q    <= tx_word;
        reload_q <= cpha;
        cnt_q    <= '0;
      end else begin
        if (shift_ev) begin
          if (reload_q) begin
            tx_sr    <= nxt_q;
            reload_q <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
          end
        end
        if (sample_ev) begin
          rx_sr <= {rx_sr[WORD_W-2:0], mosi_s};
          if (done_w) begin
            rx_word  <= {rx_sr[WORD_W-2:0], mosi_s};
            rx_valid <= 1'b1;
            cnt_q    <= '0;
            nxt_q    <= tx_word;
            reload_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign miso_d  = tx_sr[WORD_W-1];
  assign miso_oe = active_q;

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample_ev));
  // R8
  valid_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sel_act));
  // R9
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sel_act && !shift_ev) |=> $stable(miso_d));
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              sel_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [2:0] pins_s;
  logic       sample_ev, shift_ev, miso_d, sel_act;

  spi_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({sel_n, mosi, sclk}), .d_out(pins_s)
  );

  assign sel_act = ~pins_s[2];

  spi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[0]),
    .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sample_ev(sample_ev), .shift_ev(shift_ev)
  );

  spi_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .mosi_s(pins_s[1]),
    .sample_ev(sample_ev), .shift_ev(shift_ev), .cpha(cfg_cpha),
    .tx_word(tx_word), .rx_word(rx_word), .rx_valid(rx_valid),
    .miso_d(miso_d), .miso_oe(miso_oe)
  );

  assign miso = miso_oe ? miso_d : 1'bz;

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[2] |=> !miso_oe);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(miso_oe));
endmodule

// File: tb/tb_spi_word_slave.sv
module tb_spi_word_slave;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, sel_n = 1'b1;
  logic miso, miso_oe, rx_valid;
  logic [W-1:0] tx_word = '0, rx_word;

  int checks = 0, fails = 0, vcnt = 0;
  logic [W-1:0] rx_last = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_word_slave #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sclk(sclk), .mosi(mosi), .sel_n(sel_n), .miso(miso), .miso_oe(miso_oe),
    .tx_word(tx_word), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (rx_valid) begin
    vcnt <= vcnt + 1;
    rx_last <= rx_word;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bit as the master sees it; returns the bit read from miso.
  task automatic one_bit(input bit pol, input bit pha, input bit mb, output bit got);
    if (!pha) begin
      mosi = mb; wc(4); got = miso;
      sclk = ~pol; wc(4); sclk = pol;
    end else begin
      sclk = ~pol; wc(2); mosi = mb; wc(2); got = miso;
      sclk = pol; wc(4);
    end
  endtask

  // Frame of one or two words; checks both directions and the strobe count.
  task automatic run_frame(input bit pol, input bit pha, input int nw,
                           input logic [W-1:0] m0, input logic [W-1:0] m1,
                           input logic [W-1:0] s0, input logic [W-1:0] s1);
    logic [W-1:0] got, mw, sw;
    bit b;
    int base;
    sel_n = 1'b1; cfg_cpol = pol; cfg_cpha = pha; sclk = pol; tx_word = s0;
    wc(6);
    sel_n = 1'b0; wc(6);
    check(miso_oe == 1'b1, "R2 oe after select", int'(miso_oe), 1);
    if (!pha) check(miso == s0[W-1], "R4 msb before clock", int'(miso), int'(s0[W-1]));
    base = vcnt;
    for (int w = 0; w < nw; w++) begin
      mw = (w == 0) ? m0 : m1;
      sw = (w == 0) ? s0 : s1;
      for (int i = W-1; i >= 0; i--) begin
        one_bit(pol, pha, mw[i], b);
        got[i] = b;
        if (w == 0 && i == W-1) tx_word = s1;
      end
      wc(4);
      check(got == sw, (w == 0) ? "R3 slave word seen by master" : "R7 next word",
            int'(got), int'(sw));
      check(rx_last == mw, "R5 master word received", int'(rx_last), int'(mw));
      check(vcnt == base + w + 1, "R6 one strobe per word", vcnt, base + w + 1);
    end
    sel_n = 1'b1; wc(6);
    check(miso_oe == 1'b0, "R2 released after frame", int'(miso_oe), 0);
  endtask

  task automatic t_reset();
    wc(3);
    check(miso_oe == 1'b0, "R1 oe at reset", int'(miso_oe), 0);
    check(rx_valid == 1'b0, "R1 valid at reset", int'(rx_valid), 0);
    rst_n = 1'b1; wc(4);
    check(miso_oe == 1'b0 && vcnt == 0, "R1 quiet after reset", vcnt, 0);
  endtask

  task automatic t_modes();
    run_frame(1'b0, 1'b0, 1, 8'hA5, 8'h00, 8'h3C, 8'h00);
    run_frame(1'b0, 1'b1, 1, 8'h96, 8'h00, 8'hC1, 8'h00);
    run_frame(1'b1, 1'b0, 1, 8'h0F, 8'h00, 8'hE2, 8'h00);
    run_frame(1'b1, 1'b1, 1, 8'h81, 8'h00, 8'h5A, 8'h00);
  endtask

  task automatic t_back_to_back();
    run_frame(1'b0, 1'b0, 2, 8'h12, 8'hED, 8'h77, 8'h8E);
    run_frame(1'b1, 1'b1, 2, 8'hF0, 8'h69, 8'h01, 8'hB4);
    run_frame(1'b0, 1'b1, 2, 8'h55, 8'hAA, 8'hFF, 8'h80);
  endtask

  task automatic t_deselected();
    int base;
    base = vcnt;
    sel_n = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    for (int k = 0; k < 12; k++) begin
      mosi = k[0]; sclk = ~sclk; wc(4);
      check(miso_oe == 1'b0, "R2 oe low while deselected", int'(miso_oe), 0);
    end
    sclk = 1'b0; wc(4);
    check(vcnt == base, "R2 no strobe while deselected", vcnt, base);
    run_frame(1'b0, 1'b0, 1, 8'hC3, 8'h00, 8'h9D, 8'h00);
  endtask

  task automatic t_cut_short();
    int base;
    bit b;
    base = vcnt;
    sel_n = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; sclk = 1'b0; tx_word = 8'h44;
    wc(6); sel_n = 1'b0; wc(6);
    for (int i = 0; i < 3; i++) one_bit(1'b0, 1'b0, 1'b1, b);
    sel_n = 1'b1; wc(8);
    check(vcnt == base, "R8 partial word dropped", vcnt, base);
    check(miso_oe == 1'b0, "R8 released after cut", int'(miso_oe), 0);
    run_frame(1'b0, 1'b0, 1, 8'h3A, 8'h00, 8'h6B, 8'h00);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_back_to_back();
    t_deselected();
    t_cut_short();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule